// File: doc/BRIEF.md
# Flash Write-Protection Gate

This unit decides, one request at a time, whether a CPU write, erase or read aimed at an on-chip flash region may proceed. A request names a region, a byte offset inside that region and an operation. The unit combines it with three per-section write-enable registers and a global protect flag. The flag comes from a protection word that is captured only while reset is held. One cycle after each request, the unit returns a verdict of allowed or refused.

The regions covered are:
- two 128 KiB program blocks, each with sixteen 8 KiB sections;
- an 8 KiB data block with sixteen 512-byte sections;
- three 128-byte information blocks.

When an information-block erase is allowed, the unit also flags the main block that must be cleared along with it. A refused request produces a one-cycle error pulse and never raises an erase-companion flag. The array, the timing and the sequencing of flash programming are handled elsewhere.

Top module: `fprot_guard`

## Requirements
- R1: The response is registered. `resp_valid` follows `req_valid` one cycle later. On every response exactly one of `resp_ok` and `resp_err` is 1. With no request, or during reset, all five outputs are 0.
- R2: For region code 0 (program block A) or 1 (program block B), a write (op 0) or erase (op 1) is allowed only when the offset is below 20000h and the enable bit indexed by offset bits 16:13 is set. Block A uses `we_prog_a` and block B uses `we_prog_b`, with bit 0 covering the lowest section.
- R3: For region code 2 (data block), a write or erase is allowed only when the offset is below 2000h and `we_data` bit [offset bits 12:9] is set.
- R4: For region code 3 (factory information block), every write and erase is refused, whatever the enables and the protect flag.
- R5: For region code 4 (user information block B), a write or erase is allowed only when the offset is below 80h, `we_prog_b` bit 0 is set, and the global protect flag is 0.
- R6: For region code 5 (user information block D), a write or erase is allowed only when the offset is below 80h and the global protect flag is 0.
- R7: A read (op 2) within the region's size is allowed for every region code 0 to 5, whatever the enables and the protect flag.
- R8: An allowed erase of region 4 sets `erase_prog_b`. An allowed erase of region 5 sets `erase_data`. No other response sets either flag.
- R9: A refused request gives `resp_err`=1 for exactly the one response cycle, with both erase flags 0.
- R10: The global protect flag is bit 0 of a protection word copied from `pw_store` on each clock edge while `rst_n` is 0 (1 = protected). After reset is released, changes on `pw_store` and writes to region 4 offset 7Eh leave decisions unchanged until the next reset.
- R11: The following are refused: region codes 6 and 7, op code 3, and any offset at or beyond the region's size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads the protection word |
| req_valid | input | 1 | Request present this cycle |
| req_region | input | 3 | Region code 0..5 |
| req_op | input | 2 | 0 write, 1 erase, 2 read, 3 reserved |
| req_addr | input | 17 | Byte offset within the region |
| we_prog_a | input | 16 | Section write enables, program block A |
| we_prog_b | input | 16 | Section write enables, program block B |
| we_data | input | 16 | Section write enables, data block |
| pw_store | input | 16 | Stored protection word value |
| resp_valid | output | 1 | Verdict present |
| resp_ok | output | 1 | Request allowed |
| resp_err | output | 1 | Request refused (one-cycle pulse) |
| erase_prog_b | output | 1 | Allowed erase must also clear program block B |
| erase_data | output | 1 | Allowed erase must also clear the data block |

## Verification
The hardest behaviour to reach from the ports is the delayed effect of the protection word. A new value must not alter any decision until a later reset, and then it must take hold at once. The stimulus leaves reset with the word protected, then flips `pw_store` while information-block writes are issued. It also writes to the protection-word offset itself. Reset is then re-entered mid-run with the opposite value, and the same requests are repeated. A long random phase varies the enables and `pw_store` on every request, so a latch that leaks outside reset would show up as a mismatch against the bench model.

// File: rtl/fprot_pkg.sv
package fprot_pkg;
  typedef enum logic [2:0] {
    RG_PROG_A = 3'd0,
    RG_PROG_B = 3'd1,
    RG_DATA   = 3'd2,
    RG_FACT   = 3'd3,
    RG_USER_B = 3'd4,
    RG_USER_D = 3'd5
  } region_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_ERASE = 2'd1,
    OP_READ  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef struct packed {
    logic ok;
    logic casc_prog_b;
    logic casc_data;
  } verdict_t;
endpackage

// File: rtl/fprot_pw_latch.sv
module fprot_pw_latch #(
  parameter int PW_W   = 16,
  parameter int GP_BIT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW_W-1:0] pw_store,
  output logic            global_prot
);
  logic [PW_W-1:0] pw_q;
  logic            unused_pw_bits;

  // Captured only while reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) pw_q <= pw_store;
  end

  assign global_prot    = pw_q[GP_BIT];
  assign unused_pw_bits = ^pw_q;

  // R10: word frozen once out of reset
  a_r10_pw_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(pw_q));
endmodule

// File: rtl/fprot_decide.sv
module fprot_decide
  import fprot_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int SECT_N   = 16,
  parameter int PROG_LG  = 13,
  parameter int DATA_LG  = 9,
  parameter int INFO_LG  = 7,
  parameter int UB_EN_IX = 0
) (
  input  logic [2:0]        region,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SECT_N-1:0] we_prog_a,
  input  logic [SECT_N-1:0] we_prog_b,
  input  logic [SECT_N-1:0] we_data,
  input  logic              global_prot,
  output logic              range_ok,
  output logic              mutable,
  output verdict_t          verdict
);
  localparam int SECT_W = $clog2(SECT_N);

  function automatic logic fits(input logic [ADDR_W-1:0] a, input int lg);
    return (a >> lg) == '0;
  endfunction

  function automatic logic [SECT_W-1:0] sect_of(input logic [ADDR_W-1:0] a, input int lg);
    logic [ADDR_W-1:0] s;
    s = a >> lg;
    return s[SECT_W-1:0];
  endfunction

  logic is_read, is_mod, is_erase;
  assign is_read  = (op == OP_READ);
  assign is_erase = (op == OP_ERASE);
  assign is_mod   = (op == OP_WRITE) || is_erase;

  always_comb begin
    range_ok = 1'b0;
    mutable  = 1'b0;
    case (region_e'(region))
      RG_PROG_A: begin
        range_ok = fits(addr, PROG_LG + SECT_W);
        mutable  = we_prog_a[sect_of(addr, PROG_LG)];
      end
      RG_PROG_B: begin
        range_ok = fits(addr, PROG_LG + SECT_W);
        mutable  = we_prog_b[sect_of(addr, PROG_LG)];
      end
      RG_DATA: begin
        range_ok = fits(addr, DATA_LG + SECT_W);
        mutable  = we_data[sect_of(addr, DATA_LG)];
      end
      RG_FACT: begin
        range_ok = fits(addr, INFO_LG);
        mutable  = 1'b0;
      end
      RG_USER_B: begin
        range_ok = fits(addr, INFO_LG);
        mutable  = we_prog_b[UB_EN_IX] && !global_prot;
      end
      RG_USER_D: begin
        range_ok = fits(addr, INFO_LG);
        mutable  = !global_prot;
      end
      default: begin
        range_ok = 1'b0;
        mutable  = 1'b0;
      end
    endcase
  end

  always_comb begin
    verdict.ok          = range_ok && (is_read || (is_mod && mutable));
    verdict.casc_prog_b = verdict.ok && is_erase && (region == RG_USER_B);
    verdict.casc_data   = verdict.ok && is_erase && (region == RG_USER_D);
  end
endmodule

// File: rtl/fprot_guard.sv
module fprot_guard
  import fprot_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int SECT_N = 16,
  parameter int PW_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_region,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SECT_N-1:0] we_prog_a,
  input  logic [SECT_N-1:0] we_prog_b,
  input  logic [SECT_N-1:0] we_data,
  input  logic [PW_W-1:0]   pw_store,
  output logic              resp_valid,
  output logic              resp_ok,
  output logic              resp_err,
  output logic              erase_prog_b,
  output logic              erase_data
);
  logic     global_prot;
  logic     range_ok, mutable;
  verdict_t verdict;

  fprot_pw_latch #(.PW_W(PW_W), .GP_BIT(0)) u_pw (
    .clk(clk), .rst_n(rst_n), .pw_store(pw_store), .global_prot(global_prot)
  );

  fprot_decide #(.ADDR_W(ADDR_W), .SECT_N(SECT_N)) u_dec (
    .region(req_region), .op(req_op), .addr(req_addr),
    .we_prog_a(we_prog_a), .we_prog_b(we_prog_b), .we_data(we_data),
    .global_prot(global_prot), .range_ok(range_ok), .mutable(mutable),
    .verdict(verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_ok      <= 1'b0;
      resp_err     <= 1'b0;
      erase_prog_b <= 1'b0;
      erase_data   <= 1'b0;
    end else begin
      resp_valid   <= req_valid;
      resp_ok      <= req_valid && verdict.ok;
      resp_err     <= req_valid && !verdict.ok;
      erase_prog_b <= req_valid && verdict.casc_prog_b;
      erase_data   <= req_valid && verdict.casc_data;
    end
  end

  // R1: a request is answered on the next cycle
  a_r1_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  // R1: one verdict per response, none without
  a_r1_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid ? (resp_ok ^ resp_err) : !(resp_ok || resp_err));
  // R4: factory block never modifiable
  a_r4_factory_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_region == 3'd3 && req_op != 2'd2) |=> resp_err);
  // R9: refusal carries no erase companion
  a_r9_deny_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> !(erase_prog_b || erase_data));
  // R8: companion flags only from matching erase requests
  a_r8_casc_src_b: assert property (@(posedge clk) disable iff (!rst_n)
    erase_prog_b |-> ($past(req_region) == 3'd4 && $past(req_op) == 2'd1));
  a_r8_casc_src_d: assert property (@(posedge clk) disable iff (!rst_n)
    erase_data |-> ($past(req_region) == 3'd5 && $past(req_op) == 2'd1));
  // R11: unknown region codes are never allowed
  a_r11_bad_region: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_region > 3'd5) |=> !resp_ok);
endmodule

// File: tb/fprot_guard_test.sv
`timescale 1ns/1ps
module fprot_guard_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_region;
  logic [1:0]  req_op;
  logic [16:0] req_addr;
  logic [15:0] we_prog_a, we_prog_b, we_data, pw_store;
  logic        resp_valid, resp_ok, resp_err, erase_prog_b, erase_data;

  int total = 0;
  int bad   = 0;
  bit model_prot;
  bit done = 0;

  always #2 clk = ~clk;

  fprot_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_region(req_region),
    .req_op(req_op), .req_addr(req_addr), .we_prog_a(we_prog_a),
    .we_prog_b(we_prog_b), .we_data(we_data), .pw_store(pw_store),
    .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_err(resp_err),
    .erase_prog_b(erase_prog_b), .erase_data(erase_data)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: verdict for one request
  function automatic void ref_model(input int rg, input int op, input int addr,
                                    output bit ok, output bit cb, output bit cd);
    int size;
    bit inside_reg, may;
    ok = 0; cb = 0; cd = 0;
    if (rg > 5 || op == 3) return;
    if (rg <= 1) size = 131072; else if (rg == 2) size = 8192; else size = 128;
    inside_reg = addr < size;
    if (!inside_reg) return;
    if (op == 2) begin ok = 1; return; end
    case (rg)
      0: may = we_prog_a[addr / 8192];
      1: may = we_prog_b[addr / 8192];
      2: may = we_data[addr / 512];
      3: may = 0;
      4: may = we_prog_b[0] && !model_prot;
      default: may = !model_prot;
    endcase
    ok = may;
    cb = ok && op == 1 && rg == 4;
    cd = ok && op == 1 && rg == 5;
  endfunction

  // Drive at negedge, compare at the following negedge (one register stage)
  task automatic issue(input string tag, input int rg, input int op, input int addr);
    bit ok, cb, cd;
    req_valid  = 1'b1;
    req_region = rg[2:0];
    req_op     = op[1:0];
    req_addr   = addr[16:0];
    ref_model(rg, op, addr, ok, cb, cd);
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, "resp_valid", resp_valid, 1);
    check(tag, "resp_ok", resp_ok, ok);
    check(ok ? tag : "R9", "resp_err", resp_err, !ok);
    check((cb || cd) ? "R8" : tag, "erase_prog_b", erase_prog_b, cb);
    check((cb || cd) ? "R8" : tag, "erase_data", erase_data, cd);
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    check(tag, "idle resp_valid", resp_valid, 0);
    check(tag, "idle resp_ok", resp_ok, 0);
    check(tag, "idle resp_err", resp_err, 0);
    check(tag, "idle erase flags", {erase_prog_b, erase_data}, 0);
  endtask

  task automatic do_reset(input logic [15:0] pw);
    rst_n = 1'b0;
    pw_store = pw;
    repeat (3) @(negedge clk);
    check("R1", "reset resp_valid", resp_valid, 0);
    check("R1", "reset resp_err", resp_err, 0);
    rst_n = 1'b1;
    model_prot = pw[0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog expired: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    req_valid = 0; req_region = 0; req_op = 0; req_addr = 0;
    we_prog_a = 16'h0000; we_prog_b = 16'h0000; we_data = 16'h0000;
    @(negedge clk);
    do_reset(16'h0001);
    idle_check("R1");

    // R2: walk each section of both program blocks with alternating enables
    we_prog_a = 16'hA5C3; we_prog_b = 16'h5A3C;
    for (int s = 0; s < 16; s++) begin
      issue("R2", 0, s % 2, s * 8192 + 17);
      issue("R2", 1, (s + 1) % 2, s * 8192 + 8191);
    end
    // R3: data block sections
    we_data = 16'h8001;
    for (int s = 0; s < 16; s++) issue("R3", 2, 0, s * 512 + 3);
    issue("R11", 2, 0, 8192);
    // R4: factory block locked even with everything enabled
    we_prog_a = '1; we_prog_b = '1; we_data = '1;
    issue("R4", 3, 0, 16'h7E);
    issue("R4", 3, 1, 0);
    issue("R7", 3, 2, 16'h7E);
    // R5/R6 while protected
    issue("R5", 4, 0, 16'h10);
    issue("R6", 5, 1, 16'h10);
    issue("R7", 5, 2, 16'h10);
    // R10: change stored word and write the protection-word slot: no effect
    pw_store = 16'h0000;
    issue("R10", 4, 0, 16'h7E);
    issue("R10", 5, 0, 16'h20);
    issue("R10", 4, 1, 16'h20);
    // R10: new word takes hold after reset
    do_reset(16'hFFFE);
    issue("R10", 5, 0, 16'h20);
    issue("R8", 4, 1, 16'h00);
    issue("R8", 5, 1, 16'h7F);
    we_prog_b = 16'hFFFE;
    issue("R5", 4, 0, 16'h30);
    issue("R5", 4, 1, 16'h30);
    we_prog_b = 16'h0001;
    issue("R5", 4, 0, 16'h30);
    // R11: bad codes and offsets
    issue("R11", 6, 2, 0);
    issue("R11", 7, 0, 0);
    issue("R11", 0, 3, 0);
    issue("R11", 4, 2, 128);
    issue("R11", 5, 0, 200);
    // R9: back-to-back refusal then allowed
    issue("R9", 3, 0, 0);
    issue("R7", 0, 2, 5);
    idle_check("R9");

    // Random phase, including pw_store churn (R10)
    for (int i = 0; i < 1500; i++) begin
      int rg, op, addr;
      string tag;
      rg = $urandom_range(0, 7);
      op = $urandom_range(0, 3);
      case ($urandom_range(0, 3))
        0: addr = $urandom_range(0, 127);
        1: addr = $urandom_range(0, 8191);
        2: addr = $urandom_range(0, 131071);
        default: addr = $urandom_range(120, 8200);
      endcase
      we_prog_a = 16'($urandom); we_prog_b = 16'($urandom); we_data = 16'($urandom);
      pw_store  = 16'($urandom);
      if (rg > 5 || op == 3) tag = "R11";
      else if (op == 2) tag = "R7";
      else case (rg)
        0, 1: tag = "R2";
        2: tag = "R3";
        3: tag = "R4";
        4: tag = "R5";
        default: tag = "R6";
      endcase
      issue(tag, rg, op, addr);
      if (i == 700) do_reset(16'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule